// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the SD card clock from the host's base clock. Software controls it through one 16-bit control register at byte offset 0x2C. The register selects between two divider modes:

- **Even-divide mode** counts base clock cycles. A 10-bit divisor N gives a card clock of base / (2N).
- **Programmable mode** counts pulses of a strobe. The strobe stands for an M-times multiplied base clock, so the output is base × M / (2N).

The register also holds:

- an internal clock enable, with a read-only stable flag that rises a fixed delay after the enable is set;
- a card clock enable.

The card clock runs only while both the card clock enable and the stable flag are high.

Rate changes follow the usual SD sequence, all through writes to this one register:

1. Turn the card clock off.
2. Write the new divisor and mode.
3. Turn the card clock back on.

The divisor and mode are copied into the running divider only when the output starts from idle. A stop is deferred until the current high phase has finished. With a 100 MHz base clock, N = 125 gives the 400 kHz identification rate, N = 2 gives 25 MHz, and N = 4 gives 12.5 MHz.

Top module: `sd_card_clk_gen`

## Requirements
- R1: A write with `regWrEn` high updates the register only when `regAddr` equals 0x2C; writes to any other address change nothing. The readback layout is:
  - bits [15:8] hold divisor bits [7:0];
  - bits [7:6] hold divisor bits [9:8];
  - bit 5 is the programmable-mode select;
  - bit 2 is the card clock enable;
  - bit 1 is the stable flag, which writes cannot set;
  - bit 0 is the internal clock enable;
  - bits 4:3 read as 0.
- R2: The stable flag (bit 1) reads 1 exactly STABLE_DLY cycles after the write that sets bit 0. It reads 0 in the cycle right after the write that clears bit 0.
- R3: `sdClk` stays low unless both bit 2 and the stable flag are high. If bit 2 is set before the flag rises, the clock starts once the flag rises. In that case `sdClk` is low for STABLE_DLY + h + 1 samples after the write, where h is the half period.
- R4: In even-divide mode (bit 5 = 0) every high phase and every low phase lasts h base cycles, where h = N for N ≥ 1 and h = 1 for N = 0.
- R5: After a write that sets bit 2 while the stable flag is already 1, `sdClk` stays low for h + 1 cycles and then rises.
- R6: In programmable mode (bit 5 = 1) each phase lasts h pulses of `multTick`. A strobe with a period of T cycles therefore gives phases of h·T cycles.
- R7: Clearing bit 2 during a high phase lets that phase complete its full length, after which `sdClk` stays low. Clearing it during a low phase stops the clock with no further high pulse.
- R8: Divisor or mode writes made while the clock runs are shown on readback but do not change the output period. The new values take effect at the next start from idle.
- R9: Clearing bit 0 while the clock runs drops the stable flag at once and stops the clock at a low phase boundary. Setting bit 0 again restarts the clock with the R3 timing.
- R10: After reset the register reads 0 and `sdClk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Current control register value |
| multTick | input | 1 | One pulse per cycle of the M-times clock (programmable mode) |
| sdClk | output | 1 | Card clock |

## Verification
The bench builds the block with STABLE_DLY = 4, ADDR_W = 8 and the register at 0x2C. The short stable delay keeps every enable sequence to a few cycles, so the bench can sweep even-divide ratios 0 through 16 plus 125 and 1023; 1023 exercises the upper divisor field. It measures each phase length against h. A strobe whose period can be set from 1 to 3 cycles shows that programmable phases scale with the strobe rate. It also covers stops that arrive during a high phase and during a low phase.

// File: rtl/sd_clk_pkg.sv
package sd_clk_pkg;

  localparam int DIV_W = 10;
  localparam int REG_W = 16;

  // control register field positions (software-visible layout)
  localparam int BIT_INT_EN = 0;
  localparam int BIT_STABLE = 1;
  localparam int BIT_SD_EN  = 2;
  localparam int BIT_PROG   = 5;
  localparam int DIV_LO_POS = 8;
  localparam int DIV_HI_POS = 6;

  typedef struct packed {
    logic start;   // begin output from idle, loading configuration
    logic halt;    // stop at the next low phase
  } clk_strobe_t;

  typedef struct packed {
    logic             progSel;
    logic [DIV_W-1:0] divisor;
  } clk_cfg_t;

  function automatic logic [DIV_W-1:0] halfLen(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

endpackage

// File: rtl/sd_clk_ctrl.sv
module sd_clk_ctrl
  import sd_clk_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h2C,
  parameter int                STABLE_DLY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              dpRunning,
  output logic [REG_W-1:0]  regRdData,
  output clk_cfg_t          cfg,
  output clk_strobe_t       strobe
);

  localparam int CNT_W = $clog2(STABLE_DLY + 1);

  logic [DIV_W-1:0] divReg;
  logic             progReg;
  logic             sdEnReg;
  logic             intEnReg;
  logic             stableReg;
  logic [CNT_W-1:0] stableCnt;
  logic             stableOut;
  logic             wrHit;
  logic             runReq;
  logic             unusedWrBits;

  assign wrHit        = regWrEn && (regAddr == REG_OFFSET);
  assign unusedWrBits = ^{regWrData[4:3], regWrData[BIT_STABLE]};

  // register storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg   <= '0;
      progReg  <= 1'b0;
      sdEnReg  <= 1'b0;
      intEnReg <= 1'b0;
    end else if (wrHit) begin
      divReg   <= {regWrData[DIV_HI_POS +: 2], regWrData[DIV_LO_POS +: 8]};
      progReg  <= regWrData[BIT_PROG];
      sdEnReg  <= regWrData[BIT_SD_EN];
      intEnReg <= regWrData[BIT_INT_EN];
    end
  end

  // internal clock settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt <= '0;
      stableReg <= 1'b0;
    end else if (!intEnReg) begin
      stableCnt <= '0;
      stableReg <= 1'b0;
    end else if (stableCnt == CNT_W'(STABLE_DLY - 1)) begin
      stableReg <= 1'b1;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  assign stableOut = stableReg && intEnReg;

  always_comb begin
    regRdData                   = '0;
    regRdData[DIV_LO_POS +: 8]  = divReg[7:0];
    regRdData[DIV_HI_POS +: 2]  = divReg[9:8];
    regRdData[BIT_PROG]         = progReg;
    regRdData[BIT_SD_EN]        = sdEnReg;
    regRdData[BIT_STABLE]       = stableOut;
    regRdData[BIT_INT_EN]       = intEnReg;
  end

  assign runReq       = sdEnReg && stableOut;
  assign strobe.start = runReq && !dpRunning;
  assign strobe.halt  = !runReq;
  assign cfg.divisor  = divReg;
  assign cfg.progSel  = progReg;

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(divReg) && $stable(progReg) && $stable(sdEnReg) && $stable(intEnReg)); // R1
  AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stableReg) |-> $past(intEnReg)); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpRunning) |-> $past(sdEnReg && stableOut)); // R3

endmodule

// File: rtl/sd_clk_datapath.sv
module sd_clk_datapath
  import sd_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  clk_strobe_t strobe,
  input  clk_cfg_t    cfg,
  input  logic        multTick,
  output logic        sdClk,
  output logic        running
);

  logic             phase;
  logic             activeProg;
  logic [DIV_W-1:0] halfPer;
  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic             phaseEnd;

  // even-divide mode counts base cycles, programmable mode counts strobes
  assign tick     = activeProg ? multTick : 1'b1;
  assign phaseEnd = tick && (cnt == halfPer - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      phase      <= 1'b0;
      cnt        <= '0;
      halfPer    <= DIV_W'(1);
      activeProg <= 1'b0;
    end else if (!running) begin
      if (strobe.start) begin
        running    <= 1'b1;
        phase      <= 1'b0;
        cnt        <= '0;
        halfPer    <= halfLen(cfg.divisor);
        activeProg <= cfg.progSel;
      end
    end else if (strobe.halt && !phase) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (phaseEnd) begin
      cnt   <= '0;
      phase <= ~phase;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sdClk = phase;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !sdClk); // R3
  AST_STOP_AT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(!phase)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    running && $past(running) |-> $stable(halfPer) && $stable(activeProg)); // R8
  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    running |-> halfPer != '0); // R4

endmodule

// File: rtl/sd_card_clk_gen.sv
module sd_card_clk_gen
  import sd_clk_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h2C,
  parameter int                STABLE_DLY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              multTick,
  output logic              sdClk
);

  clk_cfg_t    cfg;
  clk_strobe_t strobe;
  logic        dpRunning;

  sd_clk_ctrl #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET),
    .STABLE_DLY(STABLE_DLY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .dpRunning(dpRunning),
    .regRdData(regRdData),
    .cfg      (cfg),
    .strobe   (strobe)
  );

  sd_clk_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfg     (cfg),
    .multTick(multTick),
    .sdClk   (sdClk),
    .running (dpRunning)
  );

endmodule

// File: tb/sd_card_clk_gen_tb.sv
module sd_card_clk_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 4;
  localparam int LIMIT      = 5000;
  localparam logic [7:0] OFS = 8'h2C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        multTick;
  logic        sdClk;

  int tickPer = 1;
  int tickCnt = 0;
  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tickCnt >= tickPer - 1) tickCnt <= 0;
    else tickCnt <= tickCnt + 1;
  end
  assign multTick = (tickCnt == 0);

  sd_card_clk_gen #(.ADDR_W(8), .REG_OFFSET(8'h2C), .STABLE_DLY(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .multTick(multTick), .sdClk(sdClk)
  );

  function automatic logic [15:0] cfgWord(int div, bit prog, bit sdEn, bit intEn);
    logic [9:0] d = div[9:0];
    return {d[7:0], d[9:8], prog, 2'b00, sdEn, 1'b0, intEn};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (sdClk == 1'b0 && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    while (sdClk == 1'b1 && g < LIMIT) begin g++; @(negedge clk); end
    while (sdClk == 1'b0 && g < LIMIT) begin g++; @(negedge clk); end
    hi = 0;
    while (sdClk == 1'b1 && hi < LIMIT) begin hi++; @(negedge clk); end
    lo = 0;
    while (sdClk == 1'b0 && lo < LIMIT) begin lo++; @(negedge clk); end
  endtask

  task automatic stayLow(int n, output bit ok);
    ok = 1'b1;
    repeat (n) begin if (sdClk) ok = 1'b0; @(negedge clk); end
  endtask

  task automatic runDiv(int n);
    int h = (n == 0) ? 1 : n;
    int lowN, hi, lo;
    wr(OFS, cfgWord(n, 0, 0, 1));
    wr(OFS, cfgWord(n, 0, 1, 1));
    countLow(lowN);
    check(lowN == h + 1, "R5 start latency", lowN, h + 1);
    measure(hi, lo);
    check(hi == h, "R4 high phase", hi, h);
    check(lo == h, "R4 low phase", lo, h);
    wr(OFS, cfgWord(n, 0, 0, 1));
    repeat (2 * h + 4) @(negedge clk);
    check(sdClk == 1'b0, "R7 idle after stop", sdClk, 0);
  endtask

  task automatic runProg(int n, int t);
    int h = (n == 0) ? 1 : n;
    int lowN, hi, lo;
    tickPer = t;
    wr(OFS, cfgWord(n, 1, 0, 1));
    wr(OFS, cfgWord(n, 1, 1, 1));
    countLow(lowN);
    measure(hi, lo);
    check(hi == h * t, "R6 prog high phase", hi, h * t);
    check(lo == h * t, "R6 prog low phase", lo, h * t);
    wr(OFS, cfgWord(n, 1, 0, 1));
    repeat (2 * h * t + 6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int n, hi, lo, tot;
    bit ok;
    repeat (3) @(negedge clk);
    check(regRdData == 16'h0, "R10 reset readback", regRdData, 0);
    check(sdClk == 1'b0, "R10 reset sdClk", sdClk, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 decode and layout
    wr(8'h28, 16'hFFFF);
    check(regRdData == 16'h0, "R1 stray address", regRdData, 0);
    wr(OFS, 16'hA5BA);
    check(regRdData == 16'hA5A0, "R1 field layout", regRdData, 16'hA5A0);
    wr(OFS, 16'h0000);

    // R2 stable timing
    wr(OFS, cfgWord(0, 0, 0, 1));
    n = 0;
    while (regRdData[1] == 1'b0 && n < LIMIT) begin n++; @(negedge clk); end
    check(n == DLY, "R2 stable delay", n, DLY);
    wr(OFS, cfgWord(0, 0, 0, 0));
    check(regRdData[1] == 1'b0, "R2 stable clears at once", regRdData[1], 0);

    // R3 clock held until stable
    wr(OFS, cfgWord(3, 0, 1, 0));
    check(regRdData == cfgWord(3, 0, 1, 0), "R3 readback sdEn only", regRdData, cfgWord(3, 0, 1, 0));
    stayLow(60, ok);
    check(ok, "R3 no clock without stable", ok, 1);
    wr(OFS, cfgWord(3, 0, 1, 1));
    countLow(n);
    check(n == DLY + 3 + 1, "R3 deferred start", n, DLY + 4);
    measure(hi, lo);
    check(hi == 3 && lo == 3, "R4 after deferred start", hi, 3);
    wr(OFS, cfgWord(3, 0, 0, 1));
    repeat (12) @(negedge clk);

    // R4 R5 even-divide sweep
    for (int d = 0; d <= 16; d++) runDiv(d);
    runDiv(125);
    runDiv(1023);

    // R7 stop during high phase
    wr(OFS, cfgWord(6, 0, 1, 1));
    countLow(n);
    wr(OFS, cfgWord(6, 0, 0, 1));
    tot = 2;
    while (sdClk == 1'b1 && tot < LIMIT) begin tot++; @(negedge clk); end
    check(tot == 6, "R7 high phase completes", tot, 6);
    stayLow(30, ok);
    check(ok, "R7 stays low after stop", ok, 1);
    // R7 stop during low phase
    wr(OFS, cfgWord(6, 0, 1, 1));
    countLow(n);
    while (sdClk == 1'b1) @(negedge clk);
    wr(OFS, cfgWord(6, 0, 0, 1));
    stayLow(30, ok);
    check(ok, "R7 stop in low phase", ok, 1);

    // R8 writes while running
    wr(OFS, cfgWord(4, 0, 1, 1));
    countLow(n);
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R8 initial rate", hi, 4);
    wr(OFS, cfgWord(9, 0, 1, 1));
    check(regRdData == (cfgWord(9, 0, 1, 1) | 16'h0002), "R8 readback new divisor",
          regRdData, cfgWord(9, 0, 1, 1) | 16'h0002);
    measure(hi, lo);
    check(hi == 4, "R8 high unchanged", hi, 4);
    check(lo == 4, "R8 low unchanged", lo, 4);
    wr(OFS, cfgWord(9, 0, 0, 1));
    repeat (20) @(negedge clk);
    wr(OFS, cfgWord(9, 0, 1, 1));
    countLow(n);
    check(n == 10, "R8 new latency after restart", n, 10);
    measure(hi, lo);
    check(hi == 9 && lo == 9, "R8 new rate after restart", hi, 9);
    wr(OFS, cfgWord(9, 0, 0, 1));
    repeat (24) @(negedge clk);

    // R6 programmable mode
    for (int t = 1; t <= 3; t++) begin
      runProg(0, t);
      runProg(1, t);
      runProg(2, t);
      runProg(5, t);
    end
    tickPer = 1;

    // R9 internal enable cleared while running
    wr(OFS, cfgWord(5, 0, 1, 1));
    countLow(n);
    wr(OFS, cfgWord(5, 0, 1, 0));
    check(regRdData[1] == 1'b0, "R9 stable drops", regRdData[1], 0);
    repeat (7) @(negedge clk);
    stayLow(30, ok);
    check(ok, "R9 clock stopped", ok, 1);
    wr(OFS, cfgWord(5, 0, 1, 1));
    countLow(n);
    check(n == DLY + 5 + 1, "R9 restart latency", n, DLY + 6);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule